// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides what a single translated memory access may do once the page-table entry for it is known. It reads the second page-table word, the two key bits of the segment entry, the privilege state of the access, a data authority mask and an instruction authority mask (each 64 bits, one 2-bit pair per storage key), and a feature level. From these it forms the read/write/execute rights of the page, decides whether the requested fetch, load or store is allowed, and gives a fault-cause vector for a denied instruction fetch or a denied data access.

Three independent mechanisms each yield a 3-bit rights mask. The first is a table indexed by the protection code and the segment key. The second is a mask that strips execute from no-execute or guarded pages. The third is the per-key authority mask. The final rights are the bitwise AND of the three, and each mechanism that denies the access reports its own cause bit. A request is presented with `req_vld`, and the registered result appears one clock later with `rsp_vld`.

Top module: `page_perm_eval`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are cleared to zero on that edge.
- R2: `rsp_vld` equals `req_vld` from the previous cycle. When `rsp_vld` is low, `rights`, `grant`, `ifault_cause` and `dfault_cause` are all zero.
- R3: The segment key is `seg_key_user` when `priv` is 0 (unprivileged) and `seg_key_sup` when `priv` is 1.
- R4: The protection code is {`pte_word[63]`, `pte_word[1:0]`}. `rights` is {exec, write, read}. With key 0, codes 0, 1 and 2 give 3'b111, codes 3 and 6 give 3'b101, and all other codes give 0. With key 1, code 2 gives 3'b111, codes 1 and 3 give 3'b101, and all other codes give 0.
- R5: If `pte_word[2]` (no-execute) or `pte_word[3]` (guarded) is set, execute is removed and read and write are left as they are.
- R6: The storage key is `pte_word[8:4]`. When `feat_lvl` is 1 or more, the data mask pair at bits [2*(31-key)+1 : 2*(31-key)] applies. Its upper bit removes write and its lower bit removes read. At `feat_lvl` 0 the pair has no effect.
- R7: When `feat_lvl` is 2 or 3, the lower bit of the instruction mask pair at the same position removes execute. Below level 2 the instruction mask has no effect.
- R8: `rights` is the AND of the results of R4, R5, R6 and R7. `acc_type` is 0 for fetch (needs exec), 1 for load (needs read), 2 for store (needs write) and 3 for load. `grant` is 1 exactly when every needed right is present.
- R9: A denied fetch sets `ifault_cause` as follows. Bit 0 is set when R5 removed execute. Bit 1 is set when the table of R4 lacks execute and bit 0 is clear. Bit 2 is set when the instruction mask removed execute. In all other cases `ifault_cause` is 0.
- R10: A denied load or store sets `dfault_cause` as follows. Bit 0 is set when the table lacks the needed right. Bit 1 is set when the access is a store. Bit 2 is set when the data mask removed the needed right. In all other cases `dfault_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request valid |
| acc_type | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| priv | input | 1 | 1 for a privileged access |
| seg_key_user | input | 1 | Segment key used for unprivileged accesses |
| seg_key_sup | input | 1 | Segment key used for privileged accesses |
| pte_word | input | 64 | Second page-table word |
| data_mask | input | 64 | Data authority mask, 2 bits per key |
| instr_mask | input | 64 | Instruction authority mask, 2 bits per key |
| feat_lvl | input | 2 | 0 no masks, 1 data mask, 2 or 3 both masks |
| rsp_vld | output | 1 | Result valid, one cycle after request |
| rights | output | 3 | Granted rights {exec, write, read} |
| grant | output | 1 | Requested access allowed |
| ifault_cause | output | 3 | {instr mask, protection, no-exec/guard} |
| dfault_cause | output | 3 | {data mask, store, protection} |

## Verification
The assertions assume that the request inputs are stable across the capturing edge and that `req_vld` is a known value after reset. They also assume that the cause vectors can only be nonzero for a denied access of the matching kind. The stimulus drives every input on the falling edge and holds it for a full cycle. It sweeps every protection code, privilege and key combination, no-execute/guard pair, access type and feature level, together with all values of the selected mask pairs. The selected key changes with each vector, and every unselected pair is set to all ones, so a pair taken from the wrong position changes the result.

// File: rtl/perm_pkg.sv
package perm_pkg;
  localparam int RT_R = 0;
  localparam int RT_W = 1;
  localparam int RT_X = 2;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef struct packed {
    logic [2:0] tbl;
    logic [2:0] nxg;
    logic [2:0] msk;
  } rights_set_t;
endpackage

// File: rtl/perm_pp_table.sv
module perm_pp_table (
  input  logic       key,
  input  logic [2:0] code,
  output logic [2:0] rt
);
  always_comb begin
    rt = 3'b000;
    if (!key) begin
      unique case (code)
        3'd0, 3'd1, 3'd2: rt = 3'b111;
        3'd3, 3'd6:       rt = 3'b101;
        default:          rt = 3'b000;
      endcase
    end else begin
      unique case (code)
        3'd2:       rt = 3'b111;
        3'd1, 3'd3: rt = 3'b101;
        default:    rt = 3'b000;
      endcase
    end
  end

  // R4
  always_comb begin
    write_has_read_chk: assert (!(rt[1] && !rt[0]));
  end
endmodule

// File: rtl/perm_auth_mask.sv
module perm_auth_mask #(
  parameter int NUM_KEYS = 32,
  localparam int KEY_W  = $clog2(NUM_KEYS),
  localparam int MASK_W = 2 * NUM_KEYS
) (
  input  logic [MASK_W-1:0] data_mask,
  input  logic [MASK_W-1:0] instr_mask,
  input  logic [KEY_W-1:0]  key,
  input  logic [1:0]        feat_lvl,
  output logic [2:0]        rt
);
  logic [1:0] dpair [NUM_KEYS];
  logic [1:0] ipair [NUM_KEYS];

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_pair
    assign dpair[g] = data_mask[2*(NUM_KEYS-1-g) +: 2];
    assign ipair[g] = instr_mask[2*(NUM_KEYS-1-g) +: 2];
  end

  logic [1:0] dsel, isel;
  assign dsel = dpair[key];
  assign isel = ipair[key];

  always_comb begin
    rt = 3'b111;
    if (feat_lvl != 2'd0) begin
      if (dsel[1]) rt[1] = 1'b0;
      if (dsel[0]) rt[0] = 1'b0;
    end
    if (feat_lvl[1] && isel[0]) rt[2] = 1'b0;
  end
endmodule

// File: rtl/perm_fault_encode.sv
module perm_fault_encode
  import perm_pkg::*;
(
  input  acc_e        acc,
  input  rights_set_t rs,
  output logic [2:0]  rt,
  output logic        grant,
  output logic [2:0]  icause,
  output logic [2:0]  dcause
);
  logic [2:0] need;

  always_comb begin
    unique case (acc)
      ACC_FETCH: need = 3'b100;
      ACC_STORE: need = 3'b010;
      default:   need = 3'b001;
    endcase
  end

  assign rt    = rs.tbl & rs.nxg & rs.msk;
  assign grant = ((need & ~rt) == 3'b000);

  always_comb begin
    icause = 3'b000;
    dcause = 3'b000;
    if (!grant) begin
      if (acc == ACC_FETCH) begin
        icause[0] = !rs.nxg[RT_X];
        icause[1] = rs.nxg[RT_X] && !rs.tbl[RT_X];
        icause[2] = !rs.msk[RT_X];
      end else begin
        dcause[0] = |(need & ~rs.tbl);
        dcause[1] = (acc == ACC_STORE);
        dcause[2] = |(need & ~rs.msk);
      end
    end
  end
endmodule

// File: rtl/page_perm_eval.sv
module page_perm_eval
  import perm_pkg::*;
#(
  parameter int NUM_KEYS = 32,
  parameter int PTE_W    = 64,
  localparam int KEY_W   = $clog2(NUM_KEYS),
  localparam int MASK_W  = 2 * NUM_KEYS,
  localparam int KEY_LSB = 4,
  localparam int PPHI_BIT = PTE_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic [1:0]        acc_type,
  input  logic              priv,
  input  logic              seg_key_user,
  input  logic              seg_key_sup,
  input  logic [PTE_W-1:0]  pte_word,
  input  logic [MASK_W-1:0] data_mask,
  input  logic [MASK_W-1:0] instr_mask,
  input  logic [1:0]        feat_lvl,
  output logic              rsp_vld,
  output logic [2:0]        rights,
  output logic              grant,
  output logic [2:0]        ifault_cause,
  output logic [2:0]        dfault_cause
);
  logic              seg_key;
  logic [2:0]        code;
  logic [KEY_W-1:0]  pg_key;
  rights_set_t       rs;
  logic [2:0]        rt_c, icause_c, dcause_c;
  logic              grant_c;

  assign seg_key = priv ? seg_key_sup : seg_key_user;
  assign code    = {pte_word[PPHI_BIT], pte_word[1:0]};
  assign pg_key  = pte_word[KEY_LSB +: KEY_W];
  assign rs.nxg  = (pte_word[2] || pte_word[3]) ? 3'b011 : 3'b111;

  perm_pp_table u_tbl (
    .key  (seg_key),
    .code (code),
    .rt   (rs.tbl)
  );

  perm_auth_mask #(.NUM_KEYS(NUM_KEYS)) u_mask (
    .data_mask  (data_mask),
    .instr_mask (instr_mask),
    .key        (pg_key),
    .feat_lvl   (feat_lvl),
    .rt         (rs.msk)
  );

  perm_fault_encode u_enc (
    .acc    (acc_e'(acc_type)),
    .rs     (rs),
    .rt     (rt_c),
    .grant  (grant_c),
    .icause (icause_c),
    .dcause (dcause_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld      <= 1'b0;
      rights       <= 3'b000;
      grant        <= 1'b0;
      ifault_cause <= 3'b000;
      dfault_cause <= 3'b000;
    end else begin
      rsp_vld      <= req_vld;
      rights       <= req_vld ? rt_c     : 3'b000;
      grant        <= req_vld && grant_c;
      ifault_cause <= req_vld ? icause_c : 3'b000;
      dfault_cause <= req_vld ? dcause_c : 3'b000;
    end
  end

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_vld |-> (rights == 3'b000 && !grant && ifault_cause == 3'b000 && dfault_cause == 3'b000));
  // R8
  grant_clean_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> (ifault_cause == 3'b000 && dfault_cause == 3'b000));
  // R9
  icause_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ifault_cause[1:0]));
  // R10
  store_denied_chk: assert property (@(posedge clk) disable iff (rst)
    dfault_cause[1] |-> (!grant && ifault_cause == 3'b000));
endmodule

// File: tb/page_perm_eval_test.sv
module page_perm_eval_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, req_vld, priv, seg_key_user, seg_key_sup;
  logic [1:0]  acc_type, feat_lvl;
  logic [63:0] pte_word, data_mask, instr_mask;
  logic        rsp_vld, grant;
  logic [2:0]  rights, ifault_cause, dfault_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  page_perm_eval uut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .acc_type(acc_type), .priv(priv),
    .seg_key_user(seg_key_user), .seg_key_sup(seg_key_sup), .pte_word(pte_word),
    .data_mask(data_mask), .instr_mask(instr_mask), .feat_lvl(feat_lvl),
    .rsp_vld(rsp_vld), .rights(rights), .grant(grant),
    .ifault_cause(ifault_cause), .dfault_cause(dfault_cause)
  );

  function automatic logic [2:0] tbl_model(input logic k, input int c);
    if (!k) return (c <= 2) ? 3'b111 : ((c == 3 || c == 6) ? 3'b101 : 3'b000);
    return (c == 2) ? 3'b111 : ((c == 1 || c == 3) ? 3'b101 : 3'b000);
  endfunction

  task automatic cmp(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt = 0;
    rst = 1; req_vld = 0; acc_type = 0; priv = 0; seg_key_user = 0; seg_key_sup = 0;
    pte_word = '0; data_mask = '0; instr_mask = '0; feat_lvl = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1 rsp_vld", {3'b0, rsp_vld}, 4'h0);
    cmp("R1 rights", {1'b0, rights}, 4'h0);
    cmp("R1 causes", {1'b0, ifault_cause | dfault_cause}, 4'h0);
    rst = 0;
    @(negedge clk);
    // R2: idle gives zero outputs
    cmp("R2 idle", {grant, rights}, 4'h0);
    cmp("R2 idle vld", {3'b0, rsp_vld}, 4'h0);

    for (int pc = 0; pc < 8; pc++)
    for (int pv = 0; pv < 2; pv++)
    for (int ku = 0; ku < 2; ku++)
    for (int ks = 0; ks < 2; ks++)
    for (int ng = 0; ng < 4; ng++)
    for (int ac = 0; ac < 4; ac++)
    for (int lv = 0; lv < 4; lv++)
    for (int dp = 0; dp < 4; dp++)
    for (int ip = 0; ip < 4; ip++) begin
      int key;
      logic k;
      logic [2:0] pr, ex, am, rt, need, ic, dc;
      logic gr;
      key = cnt % 32;
      cnt++;
      req_vld = 1; acc_type = 2'(ac); priv = pv[0];
      seg_key_user = ku[0]; seg_key_sup = ks[0]; feat_lvl = 2'(lv);
      pte_word = '0;
      pte_word[1:0] = pc[1:0];
      pte_word[63]  = pc[2];
      pte_word[2]   = ng[0];
      pte_word[3]   = ng[1];
      pte_word[8:4] = 5'(key);
      pte_word[40 + (cnt % 16)] = 1'b1;
      data_mask = '1; instr_mask = '1;
      data_mask[2*(31-key) +: 2]  = 2'(dp);
      instr_mask[2*(31-key) +: 2] = 2'(ip);
      // R3: key choice by privilege
      k  = pv[0] ? ks[0] : ku[0];
      // R4: protection table
      pr = tbl_model(k, pc);
      // R5: no-execute / guarded
      ex = (ng != 0) ? 3'b011 : 3'b111;
      // R6, R7: authority masks
      am = 3'b111;
      if (lv >= 1) begin
        if (dp[1]) am[1] = 0;
        if (dp[0]) am[0] = 0;
      end
      if (lv >= 2 && ip[0]) am[2] = 0;
      // R8: combined rights and grant
      rt = pr & ex & am;
      need = (ac == 0) ? 3'b100 : ((ac == 2) ? 3'b010 : 3'b001);
      gr = ((need & ~rt) == 0);
      ic = 0; dc = 0;
      if (!gr && ac == 0) begin
        ic[0] = !ex[2];
        ic[1] = ex[2] && !pr[2];
        ic[2] = !am[2];
      end
      if (!gr && ac != 0) begin
        dc[0] = |(need & ~pr);
        dc[1] = (ac == 2);
        dc[2] = |(need & ~am);
      end
      @(negedge clk);
      cmp("R8 rights (R3 R4 R5 R6 R7)", {1'b0, rights}, {1'b0, rt});
      cmp("R8 grant", {3'b0, grant}, {3'b0, gr});
      cmp("R9 ifault_cause", {1'b0, ifault_cause}, {1'b0, ic});
      cmp("R10 dfault_cause", {1'b0, dfault_cause}, {1'b0, dc});
      cmp("R2 rsp_vld", {3'b0, rsp_vld}, 4'h1);
    end

    req_vld = 0;
    @(negedge clk);
    // R2: result drops when request goes away
    cmp("R2 drop", {rsp_vld, rights}, 4'h0);
    rst = 1;
    req_vld = 1;
    @(negedge clk);
    // R1: reset overrides a pending request
    cmp("R1 reset with request", {rsp_vld, rights}, 4'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule